// File: doc/BRIEF.md
# Multi-Channel Match Timer

This block holds three independent 32-bit up-counters, each paired with three match comparators, a reload value and a reload selector. A counter advances by one on every pulse of a slow tick-enable input while its run bit is set. When the count equals one of its three match values on a tick, the status bit of that comparator is set. If that comparator is the one chosen by the channel's reload selector, the next count is the reload value instead of count plus one. Setting comparator 0 to all ones with a reload value of zero gives a free-running counter that wraps.

Software configures the block through a simple register port with single-cycle write and read strobes. Read data is registered and appears one cycle after the read strobe. Counters cannot be read directly. Software writes a request to the snapshot register, naming a channel. A fixed number of cycles later the block copies that counter into the snapshot register, and a busy flag stays high until the copy is valid. Each channel drives an interrupt line from its status bits, masked by per-comparator enables. Status bits are cleared by writing ones to a clear register.

Top module: `match_timer`

## Requirements
- R1: Configuration registers are read back as written: match value k of channel c sits at word address 3*c+k (0x00 to 0x08), reload value at 0x10+c, reload selector (2 bits) at 0x14+c, interrupt enables (3 bits) at 0x1C+c, run bits (bit c for channel c) at 0x24. Unused upper bits read as 0.
- R2: A counter moves by exactly one per clock in which `tick` is high and its run bit is set. In any other clock it holds its value.
- R3: Reload selector values 1, 2 and 3 choose comparator 0, 1 and 2. On a counting clock in which the count equals the chosen match value, the next count is the reload value. Selector 0 never reloads, and the count wraps from all ones to zero.
- R4: On a counting clock in which the count equals match value k, bit k of the channel's status register (0x18+c) is set. This holds whether or not that comparator reloads.
- R5: Writing to 0x20+c clears every status bit whose data bit is 1 and leaves the bits written 0 unchanged. A match in the same clock keeps its bit set. Address 0x20+c reads as 0.
- R6: `irq[c]` is high exactly when some status bit of channel c has its enable bit set.
- R7: A write to 0x26 with data bit 0 set requests a snapshot of the channel named by data bits 5:4. Exactly 3 clocks after that write, the counter value at that moment is copied into 0x26, and later reads return it. Channel number 3 copies zero. A write with bit 0 clear has no effect.
- R8: Bit 0 of 0x27 reads 1 from the clock after an accepted request until the copy is made. A request written while busy is ignored.
- R9: Read data appears on `bus_rdata` on the clock after `bus_rd`. Addresses that map to no readable register return 0.
- R10: After a synchronous reset every register, counter and snapshot is 0, the busy flag is clear and all `irq` lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow count-enable pulse |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 3 | Per-channel interrupt request |

## Verification
A counter that skips, stalls or reloads wrongly cannot be seen directly. It shows up only through a snapshot read, three clocks after the request, or through a status bit and `irq` that rise on the wrong tick. `irq` follows status in the same clock, so a stuck or lost status bit shows up at the next cycle's comparison. A capture engine that accepts a request while busy, or latches one clock off, gives a snapshot value that differs from the one predicted for the exact latch clock. The bench therefore keeps a cycle-accurate prediction of all three counters and compares every snapshot, status read and interrupt line against it.

// File: rtl/mt_pkg.sv
// Package: shared sizes and word addresses of the match timer.
// Assumes word addressing on an 8-bit address bus.
package mt_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int NUM_CH  = 3;
    localparam int NUM_CMP = 3;
    localparam int CH_W    = $clog2(NUM_CH + 1);
    localparam int SEL_W   = $clog2(NUM_CMP + 1);

    localparam int A_MATCH   = 'h00;
    localparam int A_RELOAD  = 'h10;
    localparam int A_SELECT  = 'h14;
    localparam int A_STATUS  = 'h18;
    localparam int A_ENABLE  = 'h1C;
    localparam int A_CLEAR   = 'h20;
    localparam int A_RUN     = 'h24;
    localparam int A_SNAP    = 'h26;
    localparam int A_BUSY    = 'h27;

    typedef logic [DATA_W-1:0] word_t;

    // Word address of entry idx in the bank starting at base
    function automatic logic [ADDR_W-1:0] a_off(int base, int idx);
        return ADDR_W'(base + idx);
    endfunction
endpackage

// File: rtl/mt_regs.sv
// Module: configuration register bank of the match timer.
// Holds match, reload, selector, enable and run registers; turns writes
// to the clear bank into one-cycle per-channel clear masks.
module mt_regs
    import mt_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bus_wr,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic [DATA_W-1:0]                     bus_wdata,
    output logic [NUM_CH-1:0][NUM_CMP-1:0][DATA_W-1:0] match_o,
    output logic [NUM_CH-1:0][DATA_W-1:0]         reload_o,
    output logic [NUM_CH-1:0][SEL_W-1:0]          select_o,
    output logic [NUM_CH-1:0][NUM_CMP-1:0]        enable_o,
    output logic [NUM_CH-1:0]                     run_o,
    output logic [NUM_CH-1:0][NUM_CMP-1:0]        clear_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
            // Match value register for comparator k of channel c
            always_ff @(posedge clk) begin
                if (!rst_n)
                    match_o[c][k] <= '0;
                else if (bus_wr && bus_addr == a_off(A_MATCH, c*NUM_CMP + k))
                    match_o[c][k] <= bus_wdata;
            end
        end

        // Reload value register
        always_ff @(posedge clk) begin
            if (!rst_n)
                reload_o[c] <= '0;
            else if (bus_wr && bus_addr == a_off(A_RELOAD, c))
                reload_o[c] <= bus_wdata;
        end

        // Reload selector register
        always_ff @(posedge clk) begin
            if (!rst_n)
                select_o[c] <= '0;
            else if (bus_wr && bus_addr == a_off(A_SELECT, c))
                select_o[c] <= bus_wdata[SEL_W-1:0];
        end

        // Interrupt enable register
        always_ff @(posedge clk) begin
            if (!rst_n)
                enable_o[c] <= '0;
            else if (bus_wr && bus_addr == a_off(A_ENABLE, c))
                enable_o[c] <= bus_wdata[NUM_CMP-1:0];
        end

        // Write-one-to-clear pulse toward the channel status
        always_comb begin
            clear_o[c] = '0;
            if (bus_wr && bus_addr == a_off(A_CLEAR, c))
                clear_o[c] = bus_wdata[NUM_CMP-1:0];
        end
    end

    // Run bits, one per channel
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_o <= '0;
        else if (bus_wr && bus_addr == a_off(A_RUN, 0))
            run_o <= bus_wdata[NUM_CH-1:0];
    end
endmodule

// File: rtl/mt_channel.sv
// Module: one counter channel with its comparators and status.
// Assumes configuration inputs are registered; tick_i is a one-clock pulse.
module mt_channel
    import mt_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tick_i,
    input  logic                              run_i,
    input  logic [NUM_CMP-1:0][DATA_W-1:0]    match_i,
    input  logic [DATA_W-1:0]                 reload_i,
    input  logic [SEL_W-1:0]                  select_i,
    input  logic [NUM_CMP-1:0]                enable_i,
    input  logic [NUM_CMP-1:0]                clear_i,
    output logic [DATA_W-1:0]                 cnt_o,
    output logic [NUM_CMP-1:0]                status_o,
    output logic                              irq_o
);
    logic                 step;
    logic [NUM_CMP-1:0]   hit;
    logic                 reload_hit;

    assign step = run_i & tick_i;

    // Comparator bank: equality on counting clocks only
    always_comb begin
        for (int k = 0; k < NUM_CMP; k++)
            hit[k] = step && (cnt_o == match_i[k]);
    end

    // Pick the comparator named by the selector as reload trigger
    always_comb begin
        reload_hit = 1'b0;
        for (int k = 0; k < NUM_CMP; k++)
            if (select_i == SEL_W'(k + 1))
                reload_hit = hit[k];
    end

    // Counter: step by one or reload
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (step)
            cnt_o <= reload_hit ? reload_i : cnt_o + 1'b1;
    end

    // Status flags: set on hit, clear on request, hit wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_o <= '0;
        else
            status_o <= (status_o & ~clear_i) | hit;
    end

    assign irq_o = |(status_o & enable_i);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_o));
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !reload_hit) |=> cnt_o == $past(cnt_o) + 1'b1);
    // R3
    cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && reload_hit) |=> cnt_o == $past(reload_i));
    // R4
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((status_o & $past(hit)) == $past(hit)));
    // R5
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clear_i && !(|hit)) |=> ((status_o & $past(clear_i)) == '0));
endmodule

// File: rtl/mt_capture.sv
// Module: snapshot engine. A request names a channel; after CAP_DELAY
// clocks that counter is copied into a stable register. Requests seen
// while busy are dropped. Channel numbers past the last one copy zero.
module mt_capture
    import mt_pkg::*;
#(
    parameter int CAP_DELAY = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_i,
    input  logic [CH_W-1:0]               sel_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0] cnt_i,
    output logic                          busy_o,
    output logic [DATA_W-1:0]             value_o
);
    localparam int DLY_W = $clog2(CAP_DELAY + 1);

    logic [DLY_W-1:0] dly;
    logic [CH_W-1:0]  sel_q;
    logic [DATA_W-1:0] pick;
    logic              accept;

    assign accept = req_i && !busy_o;

    // Select the counter named in the held request
    always_comb begin
        pick = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (sel_q == CH_W'(c))
                pick = cnt_i[c];
    end

    // Request acceptance and delay countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            dly    <= '0;
            sel_q  <= '0;
        end else if (busy_o) begin
            if (dly == '0)
                busy_o <= 1'b0;
            else
                dly <= dly - 1'b1;
        end else if (accept) begin
            busy_o <= 1'b1;
            dly    <= DLY_W'(CAP_DELAY - 1);
            sel_q  <= sel_i;
        end
    end

    // Snapshot register loaded when the countdown ends
    always_ff @(posedge clk) begin
        if (!rst_n)
            value_o <= '0;
        else if (busy_o && dly == '0)
            value_o <= pick;
    end

    // R8
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);
    // R8
    busy_keep_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && dly != '0) |=> (busy_o && $stable(sel_q)));
    // R7
    latch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && dly == '0) |=> (!busy_o && value_o == $past(pick)));
endmodule

// File: rtl/match_timer.sv
// Module: top of the three-channel match timer. Wires the register bank,
// one channel per counter, the snapshot engine and the registered read mux.
// Assumes single-cycle strobes and a tick slower than clk.
module match_timer
    import mt_pkg::*;
#(
    parameter int CAP_DELAY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [2:0]        irq
);
    logic [NUM_CH-1:0][NUM_CMP-1:0][DATA_W-1:0] match_v;
    logic [NUM_CH-1:0][DATA_W-1:0]              reload_v;
    logic [NUM_CH-1:0][SEL_W-1:0]               select_v;
    logic [NUM_CH-1:0][NUM_CMP-1:0]             enable_v;
    logic [NUM_CH-1:0]                          run_v;
    logic [NUM_CH-1:0][NUM_CMP-1:0]             clear_v;
    logic [NUM_CH-1:0][DATA_W-1:0]              cnt_v;
    logic [NUM_CH-1:0][NUM_CMP-1:0]             status_v;
    logic                                       busy;
    logic [DATA_W-1:0]                          snap;
    logic [DATA_W-1:0]                          rd_mux;
    logic                                       snap_req;

    mt_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .match_o   (match_v),
        .reload_o  (reload_v),
        .select_o  (select_v),
        .enable_o  (enable_v),
        .run_o     (run_v),
        .clear_o   (clear_v)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        mt_channel chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick),
            .run_i    (run_v[c]),
            .match_i  (match_v[c]),
            .reload_i (reload_v[c]),
            .select_i (select_v[c]),
            .enable_i (enable_v[c]),
            .clear_i  (clear_v[c]),
            .cnt_o    (cnt_v[c]),
            .status_o (status_v[c]),
            .irq_o    (irq[c])
        );
    end

    assign snap_req = bus_wr && (bus_addr == a_off(A_SNAP, 0)) && bus_wdata[0];

    mt_capture #(.CAP_DELAY(CAP_DELAY)) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (snap_req),
        .sel_i   (bus_wdata[5:4]),
        .cnt_i   (cnt_v),
        .busy_o  (busy),
        .value_o (snap)
    );

    // Read decode over every readable register
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int k = 0; k < NUM_CMP; k++)
                if (bus_addr == a_off(A_MATCH, c*NUM_CMP + k))
                    rd_mux = match_v[c][k];
            if (bus_addr == a_off(A_RELOAD, c)) rd_mux = reload_v[c];
            if (bus_addr == a_off(A_SELECT, c)) rd_mux = DATA_W'(select_v[c]);
            if (bus_addr == a_off(A_STATUS, c)) rd_mux = DATA_W'(status_v[c]);
            if (bus_addr == a_off(A_ENABLE, c)) rd_mux = DATA_W'(enable_v[c]);
        end
        if (bus_addr == a_off(A_RUN, 0))  rd_mux = DATA_W'(run_v);
        if (bus_addr == a_off(A_SNAP, 0)) rd_mux = snap;
        if (bus_addr == a_off(A_BUSY, 0)) rd_mux = DATA_W'(busy);
    end

    // Registered read data, one clock after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    // R9
    rdata_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == a_off(A_BUSY, 0)) |=> bus_rdata == DATA_W'(busy ^ 1'b0) || bus_rdata[DATA_W-1:1] == '0);
endmodule

// File: tb/match_timer_tb_top.sv
// Bench: cycle-level prediction of the timer checked against its ports,
// with directed corner phases followed by seeded random traffic.
module match_timer_tb_top;
    localparam int CAP_DELAY = 3;
    localparam int RAND_OPS  = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int    errors = 0;
    int    checks = 0;
    string cur_tag = "";
    bit    done = 1'b0;

    match_timer #(.CAP_DELAY(CAP_DELAY)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    // Prediction state
    logic [31:0] m_match [3][3];
    logic [31:0] m_reload [3];
    logic [1:0]  m_sel [3];
    logic [2:0]  m_en [3];
    logic [2:0]  m_status [3];
    logic [31:0] m_cnt [3];
    logic [2:0]  m_run;
    logic        m_busy;
    int          m_dly;
    logic [1:0]  m_snap_ch;
    logic [31:0] m_snap;
    logic [31:0] exp_rd;
    logic [7:0]  rd_addr;
    bit          rd_pend;

    function automatic logic [31:0] model_read(logic [7:0] a);
        if (a < 8'h09) return m_match[a/3][a%3];
        if (a >= 8'h10 && a < 8'h13) return m_reload[a-8'h10];
        if (a >= 8'h14 && a < 8'h17) return 32'(m_sel[a-8'h14]);
        if (a >= 8'h18 && a < 8'h1B) return 32'(m_status[a-8'h18]);
        if (a >= 8'h1C && a < 8'h1F) return 32'(m_en[a-8'h1C]);
        if (a == 8'h24) return 32'(m_run);
        if (a == 8'h26) return m_snap;
        if (a == 8'h27) return 32'(m_busy);
        return 32'h0;
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (cur_tag != "") return cur_tag;
        if (a >= 8'h18 && a < 8'h1B) return "R4";
        if (a == 8'h26) return "R7";
        if (a == 8'h27) return "R8";
        if (model_read_mapped(a)) return "R1";
        return "R9";
    endfunction

    function automatic bit model_read_mapped(logic [7:0] a);
        return (a < 8'h09) || (a >= 8'h10 && a < 8'h17) ||
               (a >= 8'h1C && a < 8'h1F) || a == 8'h24;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance the prediction at each edge, then compare the outputs
    always @(posedge clk) begin
        logic [31:0] oc [3];
        for (int c = 0; c < 3; c++) oc[c] = m_cnt[c];
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin
                for (int k = 0; k < 3; k++) m_match[c][k] = '0;
                m_reload[c] = '0; m_sel[c] = '0; m_en[c] = '0;
                m_status[c] = '0; m_cnt[c] = '0;
            end
            m_run = '0; m_busy = 1'b0; m_dly = 0; m_snap_ch = '0;
            m_snap = '0; exp_rd = '0; rd_pend = 1'b0;
        end else begin
            rd_pend = bus_rd;
            if (bus_rd) begin
                exp_rd  = model_read(bus_addr);
                rd_addr = bus_addr;
            end
            if (m_busy) begin
                if (m_dly == 0) begin
                    m_snap = (m_snap_ch < 2'd3) ? oc[m_snap_ch] : 32'h0;
                    m_busy = 1'b0;
                end else m_dly--;
            end else if (bus_wr && bus_addr == 8'h26 && bus_wdata[0]) begin
                m_busy = 1'b1; m_dly = CAP_DELAY - 1; m_snap_ch = bus_wdata[5:4];
            end
            for (int c = 0; c < 3; c++) begin
                logic [2:0] hv, clr;
                bit st;
                st = m_run[c] && tick;
                hv = '0;
                for (int k = 0; k < 3; k++) if (st && oc[c] == m_match[c][k]) hv[k] = 1'b1;
                clr = (bus_wr && bus_addr == 8'(8'h20 + c)) ? bus_wdata[2:0] : 3'b0;
                m_status[c] = (m_status[c] & ~clr) | hv;
                if (st) begin
                    if (m_sel[c] != 0 && hv[m_sel[c]-1]) m_cnt[c] = m_reload[c];
                    else m_cnt[c] = oc[c] + 1;
                end
            end
            if (bus_wr) begin
                if (bus_addr < 8'h09) m_match[bus_addr/3][bus_addr%3] = bus_wdata;
                if (bus_addr >= 8'h10 && bus_addr < 8'h13) m_reload[bus_addr-8'h10] = bus_wdata;
                if (bus_addr >= 8'h14 && bus_addr < 8'h17) m_sel[bus_addr-8'h14] = bus_wdata[1:0];
                if (bus_addr >= 8'h1C && bus_addr < 8'h1F) m_en[bus_addr-8'h1C] = bus_wdata[2:0];
                if (bus_addr == 8'h24) m_run = bus_wdata[2:0];
            end
        end
        #1;
        if (!done) begin
            if (rst_n && rd_pend) check(tag_of(rd_addr), bus_rdata, exp_rd);
            for (int c = 0; c < 3; c++) begin
                if (!rst_n) check("R10", 32'(irq[c]), 32'h0);
                else check("R6", 32'(irq[c]), 32'(|(m_status[c] & m_en[c])));
            end
        end
    end

    task automatic cyc(bit wr, bit rd, logic [7:0] a, logic [31:0] d, bit tk);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick = tk;
    endtask
    task automatic wr(logic [7:0] a, logic [31:0] d, bit tk = 0); cyc(1, 0, a, d, tk); endtask
    task automatic rd(logic [7:0] a, bit tk = 0); cyc(0, 1, a, 32'h0, tk); endtask
    task automatic idle(int n, bit tk); for (int i = 0; i < n; i++) cyc(0, 0, 8'h0, 32'h0, tk); endtask
    task automatic snap_of(logic [1:0] ch, bit tk);
        wr(8'h26, {26'h0, ch, 4'h1}, tk);
        idle(CAP_DELAY + 1, tk);
        rd(8'h26, tk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7));
        idle(3, 0);
        // R10: everything reads zero after reset
        cur_tag = "R10";
        @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < 8'h28; a++) rd(8'(a));
        // R1: configuration read back
        cur_tag = "R1";
        wr(8'h05, 32'hDEADBEEF); rd(8'h05);
        wr(8'h15, 32'hFFFFFFFE); rd(8'h15);
        wr(8'h1E, 32'hFF); rd(8'h1E);
        // R9: unmapped and clear bank read zero
        cur_tag = "R9";
        rd(8'h20); rd(8'h50); rd(8'hFF);
        // R2: only channel 0 runs, ticks on alternate clocks
        cur_tag = "R2";
        wr(8'h24, 32'h1);
        for (int i = 0; i < 12; i++) idle(1, i % 2);
        snap_of(2'd0, 0); snap_of(2'd1, 0);
        // R3: channel 1 reloads from comparator 1
        cur_tag = "R3";
        wr(8'h04, 32'd4); wr(8'h11, 32'd100); wr(8'h15, 32'd2);
        wr(8'h24, 32'h7);
        idle(7, 1);
        snap_of(2'd1, 1); snap_of(2'd2, 1); snap_of(2'd3, 1);
        // R3: selector 1 reloads from comparator 0
        wr(8'h06, 32'd20); wr(8'h12, 32'd3); wr(8'h16, 32'd1);
        idle(25, 1); snap_of(2'd2, 0);
        // R4/R6: status and interrupts
        cur_tag = "R4";
        rd(8'h19); rd(8'h1A);
        wr(8'h1D, 32'h2); wr(8'h1C, 32'h0);
        // R5: partial clear, then full clear
        cur_tag = "R5";
        wr(8'h21, 32'h1); rd(8'h19);
        wr(8'h21, 32'h6); rd(8'h19);
        wr(8'h22, 32'h7, 1); rd(8'h1A);
        // R7: bit 0 clear is no request
        cur_tag = "R7";
        wr(8'h26, 32'h10); rd(8'h27); rd(8'h26);
        // R8: request while busy is dropped
        cur_tag = "R8";
        wr(8'h26, 32'h21, 1); rd(8'h27, 1);
        wr(8'h26, 32'h01, 1); rd(8'h27, 1);
        idle(2, 1); rd(8'h27); rd(8'h26);
        // Random traffic
        cur_tag = "";
        for (int i = 0; i < RAND_OPS; i++) begin
            int op;
            bit tk;
            int c;
            op = $urandom % 10; tk = ($urandom % 3) != 0; c = $urandom % 3;
            case (op)
                0: wr(8'(c*3 + $urandom % 3), $urandom % 48, tk);
                1: wr(8'(8'h10 + c), $urandom % 16, tk);
                2: wr(8'(8'h14 + c), $urandom % 4, tk);
                3: wr(8'(8'h1C + c), $urandom % 8, tk);
                4: wr(8'h24, $urandom % 8, tk);
                5: wr(8'(8'h20 + c), $urandom % 8, tk);
                6: wr(8'h26, {26'h0, 2'($urandom % 4), 3'h0, 1'($urandom % 4 != 0)}, tk);
                7: rd(8'($urandom % 8'h29), tk);
                8: rd(($urandom % 2) ? 8'h26 : 8'(8'h18 + c), tk);
                default: idle(1, tk);
            endcase
        end
        idle(2, 0);
        finish_run();
    end
endmodule